// File: doc/BRIEF.md
# Load-Use Issue Interlock

This block sits at the issue point of an in-order pipeline with a load/store path. Each cycle it sees one instruction descriptor and decides whether that instruction may leave the issue slot now or must be held. It knows whether the instruction is a memory access, whether it loads or stores, whether it moves a narrow item or a double word, and which destination and up to two source registers it names. Every access is taken to hit the cache.

Three hazards are tracked. A scoreboard keeps a countdown per register of how many more cycles a reader of that register must wait. A one-cycle port gap holds back any memory access that directly follows an issued double-word access. A shared pool of load-buffer slots limits how many loads can be in flight. Double-word loads take two slots and narrow loads take one. The stall output is combinational from the current descriptor and the registered state. All countdowns keep running while the slot is held.

Top module: `lui_interlock`

## Requirements
- R1: After a narrow load issues, an instruction that reads its destination in the next slot is held for exactly 2 cycles and issues in the third.
- R2: After a wide load into a 64-bit register (`ins_wide`=1, `ins_cp`=1) issues, a reader of that destination in the next slot is held for exactly 4 cycles.
- R3: A wide load into a core pair (`ins_wide`=1, `ins_cp`=0) writes the even register `{dst[3:1],0}` and the odd register `{dst[3:1],1}`. A reader in the next slot is held 3 cycles for the even one and 4 cycles for the odd one.
- R4: A memory access (`ins_mem`=1) presented in the cycle right after a wide load issued is held for one cycle. This includes another wide load.
- R5: A memory access presented in the cycle right after a wide store issued is held for one cycle.
- R6: Instructions that do not read the pending register issue without a hold and use up the wait. A reader that arrives once the wait has elapsed issues at once.
- R7: The load buffer has 4 slots. A narrow load needs 1 free slot and a wide load needs 2. A slot is busy for 2 cycles after a narrow load and 4 cycles after a wide one. A load that finds too few free slots is held until enough slots retire.
- R8: `stall` follows the present descriptor within the same cycle, and every countdown decreases by one each cycle, whether the slot is held or not.
- R9: When several waits apply at once, the hold lasts as long as the longest of them, not their sum.
- R10: Reset clears every countdown, the buffer slots and the port-gap flag. Right after reset, no instruction is held.
- R11: With `ins_valid`=0, both `stall` and `issue` are low, and the cycle still advances the countdowns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised on release |
| ins_valid | input | 1 | A descriptor is present in the issue slot |
| ins_mem | input | 1 | The instruction is a memory access |
| ins_load | input | 1 | For memory accesses: 1 = load, 0 = store |
| ins_wide | input | 1 | Double-word access |
| ins_cp | input | 1 | Wide access targets one 64-bit register instead of a core pair |
| ins_dst | input | 4 | Destination register (pair: either index of the pair) |
| ins_src_a_vld | input | 1 | Source A is read |
| ins_src_a | input | 4 | Source A register |
| ins_src_b_vld | input | 1 | Source B is read |
| ins_src_b | input | 4 | Source B register |
| stall | output | 1 | Hold the instruction in the issue slot this cycle |
| issue | output | 1 | The instruction leaves the issue slot this cycle |

## Verification
Two functions can fall on the same cycle. One is the one-cycle port gap after a wide access. The other is either the buffer-capacity hold or a register dependency. The bench sets up both cases on purpose. In the first, two wide loads are followed by a narrow load while both pairs of slots are still busy. The second case loads a core pair and then reads both halves at once. Each cycle's stall is compared against a hand-worked expectation. If a hold outlasts the longest pending wait, waits are being added. If it ends with the shorter wait, a hazard was dropped.

// File: rtl/lui_pkg.sv
package lui_pkg;

  typedef enum logic [1:0] {
    LK_NONE,
    LK_NARROW,
    LK_PAIR,
    LK_WIDE
  } ld_kind_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lui_scoreboard.sv
module lui_scoreboard
  import lui_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int RW       = 4,
  parameter int CW       = 3,
  parameter int S_NARROW = 2,
  parameter int S_EVEN   = 3,
  parameter int S_ODD    = 4,
  parameter int S_WIDE   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  ld_kind_e      wr_kind,
  input  logic [RW-1:0] wr_dst,
  input  logic          rd_a_vld,
  input  logic [RW-1:0] rd_a,
  input  logic          rd_b_vld,
  input  logic [RW-1:0] rd_b,
  output logic          rd_hazard
);

  logic [CW-1:0] cnt_rd [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [RW-1:0] IDX = RW'(g);

    logic          ld_en;
    logic [CW-1:0] ld_val;
    logic          cnt_en;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    // load value selection for this register
    always_comb begin
      ld_en  = 1'b0;
      ld_val = '0;
      if (wr_en) begin
        unique case (wr_kind)
          LK_NARROW: begin
            if (wr_dst == IDX) begin
              ld_en  = 1'b1;
              ld_val = CW'(S_NARROW);
            end
          end
          LK_WIDE: begin
            if (wr_dst == IDX) begin
              ld_en  = 1'b1;
              ld_val = CW'(S_WIDE);
            end
          end
          LK_PAIR: begin
            if (wr_dst[RW-1:1] == IDX[RW-1:1]) begin
              ld_en  = 1'b1;
              ld_val = IDX[0] ? CW'(S_ODD) : CW'(S_EVEN);
            end
          end
          default: ;
        endcase
      end
    end

    always_comb begin
      cnt_en = ld_en || (cnt_q != '0);
      cnt_d  = ld_en ? ld_val : (cnt_q - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt_rd[g] = cnt_q;

    // a pending count that is not reloaded drops by one each cycle
    assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  end

  always_comb begin
    rd_hazard = (rd_a_vld && (cnt_rd[rd_a] != '0)) ||
                (rd_b_vld && (cnt_rd[rd_b] != '0));
  end

  assert_narrow_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == LK_NARROW) |=> (cnt_rd[$past(wr_dst)] == CW'(S_NARROW)));

  assert_pair_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == LK_PAIR) |=>
      ((cnt_rd[{$past(wr_dst[RW-1:1]), 1'b0}] == CW'(S_EVEN)) &&
       (cnt_rd[{$past(wr_dst[RW-1:1]), 1'b1}] == CW'(S_ODD))));

endmodule

// File: rtl/lui_load_buffer.sv
module lui_load_buffer #(
  parameter int SLOTS       = 4,
  parameter int SW          = 3,
  parameter int HW          = 3,
  parameter int HOLD_NARROW = 2,
  parameter int HOLD_WIDE   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          alloc_wide,
  output logic [SW-1:0] free_cnt
);

  logic [HW-1:0] slot_q [SLOTS];
  logic [HW-1:0] slot_d [SLOTS];
  logic [SLOTS-1:0] slot_en;
  logic [1:0] need;
  logic [1:0] taken;

  always_comb begin
    need     = alloc_wide ? 2'd2 : 2'd1;
    taken    = 2'd0;
    free_cnt = '0;
    for (int s = 0; s < SLOTS; s++) begin
      slot_d[s]  = slot_q[s];
      slot_en[s] = 1'b0;
      if (slot_q[s] != '0) begin
        slot_d[s]  = slot_q[s] - 1'b1;
        slot_en[s] = 1'b1;
      end else begin
        free_cnt = free_cnt + 1'b1;
        if (alloc_en && (taken < need)) begin
          slot_d[s]  = alloc_wide ? HW'(HOLD_WIDE) : HW'(HOLD_NARROW);
          slot_en[s] = 1'b1;
          taken      = taken + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (slot_en[s]) slot_q[s] <= slot_d[s];
      end
    end
  end

  // the issue decision never allocates more slots than are free
  assert_alloc_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (free_cnt >= (alloc_wide ? SW'(2) : SW'(1))));

endmodule

// File: rtl/lui_port_gap.sv
module lui_port_gap (
  input  logic clk,
  input  logic rst_n,
  input  logic wide_issued,
  output logic gap_busy
);

  logic gap_d;

  always_comb gap_d = wide_issued;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_busy <= 1'b0;
    end else begin
      gap_busy <= gap_d;
    end
  end

endmodule

// File: rtl/lui_interlock.sv
module lui_interlock
  import lui_pkg::*;
#(
  parameter int NREG          = 16,
  parameter int SLOTS         = 4,
  parameter int WAIT_NARROW   = 2,
  parameter int WAIT_PAIR_EVN = 3,
  parameter int WAIT_PAIR_ODD = 4,
  parameter int WAIT_WIDE     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_valid,
  input  logic                    ins_mem,
  input  logic                    ins_load,
  input  logic                    ins_wide,
  input  logic                    ins_cp,
  input  logic [$clog2(NREG)-1:0] ins_dst,
  input  logic                    ins_src_a_vld,
  input  logic [$clog2(NREG)-1:0] ins_src_a,
  input  logic                    ins_src_b_vld,
  input  logic [$clog2(NREG)-1:0] ins_src_b,
  output logic                    stall,
  output logic                    issue
);

  localparam int RW        = $clog2(NREG);
  localparam int HOLD_WIDE = max2(max2(WAIT_PAIR_EVN, WAIT_PAIR_ODD), WAIT_WIDE);
  localparam int WAIT_MAX  = max2(HOLD_WIDE, WAIT_NARROW);
  localparam int CW        = $clog2(WAIT_MAX + 1);
  localparam int SW        = $clog2(SLOTS + 1);

  ld_kind_e      kind;
  logic          src_hz;
  logic          gap_busy;
  logic [SW-1:0] free_cnt;
  logic          buf_short;
  logic          is_ld;
  logic          sb_wr;
  logic          wide_issued;

  always_comb begin
    is_ld = ins_mem && ins_load;
    if (!is_ld)         kind = LK_NONE;
    else if (!ins_wide) kind = LK_NARROW;
    else if (ins_cp)    kind = LK_WIDE;
    else                kind = LK_PAIR;
  end

  always_comb begin
    buf_short   = is_ld && (free_cnt < (ins_wide ? SW'(2) : SW'(1)));
    stall       = ins_valid && (src_hz || (ins_mem && gap_busy) || buf_short);
    issue       = ins_valid && !stall;
    sb_wr       = issue && is_ld;
    wide_issued = issue && ins_mem && ins_wide;
  end

  lui_scoreboard #(
    .NREG    (NREG),
    .RW      (RW),
    .CW      (CW),
    .S_NARROW(WAIT_NARROW),
    .S_EVEN  (WAIT_PAIR_EVN),
    .S_ODD   (WAIT_PAIR_ODD),
    .S_WIDE  (WAIT_WIDE)
  ) i_scoreboard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sb_wr),
    .wr_kind  (kind),
    .wr_dst   (ins_dst),
    .rd_a_vld (ins_src_a_vld),
    .rd_a     (ins_src_a),
    .rd_b_vld (ins_src_b_vld),
    .rd_b     (ins_src_b),
    .rd_hazard(src_hz)
  );

  lui_load_buffer #(
    .SLOTS      (SLOTS),
    .SW         (SW),
    .HW         (CW),
    .HOLD_NARROW(WAIT_NARROW),
    .HOLD_WIDE  (HOLD_WIDE)
  ) i_load_buffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (sb_wr),
    .alloc_wide(ins_wide),
    .free_cnt  (free_cnt)
  );

  lui_port_gap i_port_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_issued(wide_issued),
    .gap_busy   (gap_busy)
  );

  assert_gap_after_wide_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue && ins_mem && ins_wide && ins_load) &&
     ins_valid && ins_mem) |-> stall);

  assert_gap_after_wide_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue && ins_mem && ins_wide && !ins_load) &&
     ins_valid && ins_mem) |-> stall);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> (!stall && !issue));

endmodule

// File: tb/test_lui_interlock.sv
module test_lui_interlock;

  localparam int PERIOD = 10;
  localparam int RW     = 4;
  localparam int NV     = 51;

  // columns: valid mem load wide cp dst a_vld a b_vld b exp_stall req
  localparam int TBL [NV][12] = '{
    // R1 narrow load, reader held 2 cycles
    '{1,1,1,0,0,1, 0,0,0,0, 0,1},
    '{1,0,0,0,0,0, 1,1,0,0, 1,1},
    '{1,0,0,0,0,0, 1,1,0,0, 1,1},
    '{1,0,0,0,0,0, 1,1,0,0, 0,1},
    // R2 wide load into 64-bit register, reader held 4
    '{1,1,1,1,1,2, 0,0,0,0, 0,2},
    '{1,0,0,0,0,0, 1,2,0,0, 1,2},
    '{1,0,0,0,0,0, 1,2,0,0, 1,2},
    '{1,0,0,0,0,0, 1,2,0,0, 1,2},
    '{1,0,0,0,0,0, 1,2,0,0, 1,2},
    '{1,0,0,0,0,0, 1,2,0,0, 0,2},
    // R3 pair load, even half held 3
    '{1,1,1,1,0,4, 0,0,0,0, 0,3},
    '{1,0,0,0,0,0, 0,0,1,4, 1,3},
    '{1,0,0,0,0,0, 0,0,1,4, 1,3},
    '{1,0,0,0,0,0, 0,0,1,4, 1,3},
    '{1,0,0,0,0,0, 0,0,1,4, 0,3},
    // R3 pair load, odd half held 4
    '{1,1,1,1,0,6, 0,0,0,0, 0,3},
    '{1,0,0,0,0,0, 1,7,0,0, 1,3},
    '{1,0,0,0,0,0, 1,7,0,0, 1,3},
    '{1,0,0,0,0,0, 1,7,0,0, 1,3},
    '{1,0,0,0,0,0, 1,7,0,0, 1,3},
    '{1,0,0,0,0,0, 1,7,0,0, 0,3},
    // R4 store after wide load, wide load after wide load
    '{1,1,1,1,0,8, 0,0,0,0, 0,4},
    '{1,1,0,0,0,0, 1,3,0,0, 1,4},
    '{1,1,0,0,0,0, 1,3,0,0, 0,4},
    '{1,1,1,1,1,10,0,0,0,0, 0,4},
    '{1,1,1,1,1,11,0,0,0,0, 1,4},
    '{1,1,1,1,1,11,0,0,0,0, 0,4},
    // R5 wide store, then a load right after it
    '{1,1,0,1,1,0, 1,0,0,0, 1,5},
    '{1,1,0,1,1,0, 1,0,0,0, 0,5},
    '{1,1,1,0,0,12,0,0,0,0, 1,5},
    '{1,1,1,0,0,12,0,0,0,0, 0,5},
    // R6 independent work covers the wait
    '{1,0,0,0,0,0, 1,0,0,0, 0,6},
    '{1,0,0,0,0,0, 1,0,0,0, 0,6},
    '{1,0,0,0,0,0, 1,12,0,0,0,6},
    // R7 two wide loads fill the buffer
    '{1,1,1,1,1,13,0,0,0,0, 0,7},
    '{1,0,0,0,0,0, 1,0,0,0, 0,7},
    '{1,1,1,1,1,14,0,0,0,0, 0,7},
    '{1,1,1,0,0,15,0,0,0,0, 1,7},
    '{1,1,1,0,0,15,0,0,0,0, 1,7},
    '{1,1,1,0,0,15,0,0,0,0, 0,7},
    // R11 idle slot
    '{0,0,0,0,0,0, 0,0,0,0, 0,11},
    // R9 both halves read at once: hold = max(3,4)
    '{1,1,1,1,0,6, 0,0,0,0, 0,9},
    '{1,0,0,0,0,0, 1,6,1,7, 1,9},
    '{1,0,0,0,0,0, 1,6,1,7, 1,9},
    '{1,0,0,0,0,0, 1,6,1,7, 1,9},
    '{1,0,0,0,0,0, 1,6,1,7, 1,9},
    '{1,0,0,0,0,0, 1,6,1,7, 0,9},
    // R11 invalid reader of a pending register, R8 idle cycle counts down
    '{1,1,1,0,0,9, 0,0,0,0, 0,11},
    '{0,0,0,0,0,0, 1,9,0,0, 0,11},
    '{1,0,0,0,0,0, 1,9,0,0, 1,8},
    '{1,0,0,0,0,0, 1,9,0,0, 0,8}
  };

  logic          clk;
  logic          rst_n;
  logic          ins_valid, ins_mem, ins_load, ins_wide, ins_cp;
  logic [RW-1:0] ins_dst, ins_src_a, ins_src_b;
  logic          ins_src_a_vld, ins_src_b_vld;
  logic          stall, issue;

  int n_chk;
  int n_fail;
  bit done;

  lui_interlock i_lui_interlock (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .ins_mem      (ins_mem),
    .ins_load     (ins_load),
    .ins_wide     (ins_wide),
    .ins_cp       (ins_cp),
    .ins_dst      (ins_dst),
    .ins_src_a_vld(ins_src_a_vld),
    .ins_src_a    (ins_src_a),
    .ins_src_b_vld(ins_src_b_vld),
    .ins_src_b    (ins_src_b),
    .stall        (stall),
    .issue        (issue)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input int v, input int m, input int l, input int w, input int c,
                       input int d, input int av, input int a, input int bv, input int b);
    ins_valid     = (v != 0);
    ins_mem       = (m != 0);
    ins_load      = (l != 0);
    ins_wide      = (w != 0);
    ins_cp        = (c != 0);
    ins_dst       = RW'(d);
    ins_src_a_vld = (av != 0);
    ins_src_a     = RW'(a);
    ins_src_b_vld = (bv != 0);
    ins_src_b     = RW'(b);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    drive(0,0,0,0,0,0,0,0,0,0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state: nothing pending, a reader is not held
    @(negedge clk);
    drive(1,0,0,0,0,0,1,5,1,6);
    #2;
    chk("R10", stall, 0, "stall after reset");
    chk("R10", issue, 1, "issue after reset");

    // table walk: one row per cycle
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][4],
            TBL[i][5], TBL[i][6], TBL[i][7], TBL[i][8], TBL[i][9]);
      #2;
      chk($sformatf("R%0d", TBL[i][11]), stall, TBL[i][10], $sformatf("stall row %0d", i));
      chk($sformatf("R%0d", TBL[i][11]), issue,
          ((TBL[i][0] != 0) && (TBL[i][10] == 0)) ? 1 : 0, $sformatf("issue row %0d", i));
    end

    // R8 stall follows the descriptor inside one cycle
    @(negedge clk);
    drive(1,1,1,0,0,3,0,0,0,0);
    #2;
    chk("R8", issue, 1, "narrow load to r3");
    @(negedge clk);
    drive(1,0,0,0,0,0,1,3,0,0);
    #2;
    chk("R8", stall, 1, "dependent reader");
    drive(1,0,0,0,0,0,1,0,0,0);
    #1;
    chk("R8", stall, 0, "reader swapped within cycle");
    chk("R8", issue, 1, "issue after swap");

    // R10 reset mid-flight clears waits and the port gap
    @(negedge clk);
    drive(1,1,1,1,1,4,0,0,0,0);
    #2;
    chk("R10", issue, 1, "wide load before reset");
    @(negedge clk);
    rst_n = 1'b0;
    drive(0,0,0,0,0,0,0,0,0,0);
    #2;
    rst_n = 1'b1;
    drive(1,1,0,0,0,0,1,4,0,0);
    #1;
    chk("R10", stall, 0, "store reading r4 after reset");
    drive(1,0,0,0,0,0,1,3,1,4);
    #1;
    chk("R10", stall, 0, "reader of r3 and r4 after reset");

    @(negedge clk);
    drive(0,0,0,0,0,0,0,0,0,0);
    finish_run();
  end

endmodule